// File: doc/BRIEF.md
# Remote-Write Line Watch Unit

This unit sits beside a cache controller and keeps one watched line address in a register, in place of a flag bit on every cache line. The local core gives it commands. It can load a handler address, mark a line, release the mark, or enable alerts. The unit also snoops the coherence bus. When another agent writes to the watched line, the unit raises a one-cycle alert to the local core. The alert carries the handler address and the program counter that the core presented in the snoop cycle.

The watch register is not tied to cache residency. When the line leaves the local cache, watching goes on, because the unit compares every snooped remote write against the register. Remote writes are the only trigger, so the unit keeps no record of why an alert fired. Releasing the mark also clears the handler address. Delivering an alert masks further alerts and drops the watch. Software must re-enable and re-mark before it can receive another alert.

Top module: `rww_unit`

## Requirements
- R1: After synchronous reset, `watch_active`, `alert_en`, `alert`, `mark_ack` and `mark_was_set` are 0, and `alert_vec` and `saved_pc` are 0.
- R2: A command with `cmd_op`=2'b00 (set handler) loads `cmd_arg` into `alert_vec`, visible in the cycle after the command.
- R3: A command with `cmd_op`=2'b01 (mark) stores line `cmd_arg[ADDR_W-1:6]` and sets `watch_active` in the next cycle. In that same cycle `mark_ack` pulses, and `mark_was_set` is 1 only when that same line was already watched.
- R4: Three conditions raise `alert` for exactly the one cycle after the snoop: `alert_en`=1, `watch_active`=1, and a snoop with `snp_valid`=1, `snp_write`=1 and `snp_src`≠CORE_ID targets the watched line. `saved_pc` then holds the `core_pc` of the snoop cycle.
- R5: Lines are 64 bytes. Address bits [5:0] are ignored in the compare. A write to any other line raises no alert.
- R6: Delivering an alert clears `alert_en` and `watch_active` on the same edge. A later remote write to the old line raises no alert.
- R7: Snoops with `snp_src`=CORE_ID and snoops with `snp_write`=0 never raise an alert.
- R8: A matching remote write while `alert_en`=0 raises no alert and leaves `watch_active` set.
- R9: A command with `cmd_op`=2'b10 (release) clears both `watch_active` and `alert_vec` in one operation.
- R10: A command with `cmd_op`=2'b11 (enable) sets `alert_en`.
- R11: A command presented in the same cycle as an alerting snoop has no effect. `alert_vec` keeps its old value and no `mark_ack` follows.
- R12: Only mark, release or an alert changes the watch. Any number of non-matching snoops and read snoops leaves it in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe from the local core |
| cmd_op | input | 2 | 00 set handler, 01 mark, 10 release, 11 enable |
| cmd_arg | input | ADDR_W | Handler address or line address |
| core_pc | input | ADDR_W | Current program counter of the core |
| snp_valid | input | 1 | Snoop transaction valid |
| snp_write | input | 1 | Snoop is a write or invalidate |
| snp_src | input | SRC_W | Agent that issued the snoop |
| snp_addr | input | ADDR_W | Snooped byte address |
| mark_ack | output | 1 | One-cycle response to a mark |
| mark_was_set | output | 1 | The marked line was already watched |
| watch_active | output | 1 | Watch register holds a valid line |
| alert_en | output | 1 | Alerts are enabled |
| alert | output | 1 | One-cycle alert to the core |
| alert_vec | output | ADDR_W | Handler address register |
| saved_pc | output | ADDR_W | Program counter captured at the alert |

## Verification
The hardest case to reach is an alerting snoop that arrives in the same cycle as a command. Here the alert must win and the command must leave no trace. The bench first loads a known handler. It then drives a second set-handler command together with a matching remote write. It checks that the alert fires, that the old handler value is still present, and that the program counter was captured. A long run of read snoops and writes to other lines then shows that the watch survives without any cache-residency input. After that, a single off-offset write to the line must still hit.

// File: rtl/rww_pkg.sv
package rww_pkg;
  typedef enum logic [1:0] {
    OP_SET_HANDLER = 2'b00,
    OP_MARK        = 2'b01,
    OP_RELEASE     = 2'b10,
    OP_ENABLE      = 2'b11
  } rww_op_e;
endpackage

// File: rtl/rww_line_match.sv
// Compares a snooped address against the watched line and qualifies
// the result by remote origin and write type.
module rww_line_match #(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 6,
  parameter int SRC_W    = 2,
  parameter int CORE_ID  = 0
) (
  input  logic                       snp_valid,
  input  logic                       snp_write,
  input  logic [SRC_W-1:0]           snp_src,
  input  logic [ADDR_W-1:0]          snp_addr,
  input  logic [ADDR_W-OFFSET_W-1:0] watch_line,
  input  logic                       watch_valid,
  output logic                       remote_hit
);
  localparam int LINE_W = ADDR_W - OFFSET_W;
  localparam logic [SRC_W-1:0] OWN_SRC = SRC_W'(CORE_ID);

  logic line_eq;

  generate
    if (OFFSET_W == 0) begin : g_word
      assign line_eq = (snp_addr == watch_line);
    end else begin : g_line
      logic [ADDR_W-1:0] diff;
      assign diff    = snp_addr ^ {watch_line, {OFFSET_W{1'b0}}};
      assign line_eq = (diff[ADDR_W-1:OFFSET_W] == {LINE_W{1'b0}});
    end
  endgenerate

  assign remote_hit = snp_valid && snp_write && (snp_src != OWN_SRC)
                      && watch_valid && line_eq;
endmodule

// File: rtl/rww_watch_reg.sv
// Single watched-line register with mark response.
module rww_watch_reg #(
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mark_req,
  input  logic              release_req,
  input  logic              fire,
  input  logic [LINE_W-1:0] mark_line,
  output logic [LINE_W-1:0] watch_line,
  output logic              watch_valid,
  output logic              mark_ack,
  output logic              mark_was_set
);
  always_ff @(posedge clk) begin
    if (rst) begin
      watch_line   <= '0;
      watch_valid  <= 1'b0;
      mark_ack     <= 1'b0;
      mark_was_set <= 1'b0;
    end else begin
      mark_ack     <= 1'b0;
      mark_was_set <= 1'b0;
      if (fire) begin
        watch_valid <= 1'b0;
      end else if (mark_req) begin
        watch_line   <= mark_line;
        watch_valid  <= 1'b1;
        mark_ack     <= 1'b1;
        mark_was_set <= watch_valid && (watch_line == mark_line);
      end else if (release_req) begin
        watch_valid <= 1'b0;
      end
    end
  end

  // R3: an accepted mark always leaves a valid watch
  p_mark_sets_r3: assert property (@(posedge clk) disable iff (rst)
    (mark_req && !fire) |=> (watch_valid && mark_ack));
  // R9: release drops the watch
  p_release_drops_r9: assert property (@(posedge clk) disable iff (rst)
    (release_req && !mark_req && !fire) |=> !watch_valid);
  // R6: an alert drops the watch
  p_fire_drops_r6: assert property (@(posedge clk) disable iff (rst)
    fire |=> !watch_valid);
endmodule

// File: rtl/rww_arch_regs.sv
// Handler address, saved PC, enable flag and the alert pulse.
module rww_arch_regs #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_handler_req,
  input  logic              release_req,
  input  logic              enable_req,
  input  logic [ADDR_W-1:0] handler_in,
  input  logic              fire,
  input  logic [ADDR_W-1:0] core_pc,
  output logic [ADDR_W-1:0] handler,
  output logic [ADDR_W-1:0] saved_pc,
  output logic              enable,
  output logic              alert
);
  always_ff @(posedge clk) begin
    if (rst) begin
      handler  <= '0;
      saved_pc <= '0;
      enable   <= 1'b0;
      alert    <= 1'b0;
    end else if (fire) begin
      alert    <= 1'b1;
      saved_pc <= core_pc;
      enable   <= 1'b0;
    end else begin
      alert <= 1'b0;
      if (set_handler_req) handler <= handler_in;
      if (release_req)     handler <= '0;
      if (enable_req)      enable  <= 1'b1;
    end
  end

  // R4: the alert lasts one cycle, since delivering it masks the next
  p_alert_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    alert |=> !alert);
  // R6: alert and enable are never high together
  p_alert_masks_r6: assert property (@(posedge clk) disable iff (rst)
    alert |-> !enable);
  // R11: the handler does not move across an alert
  p_handler_kept_r11: assert property (@(posedge clk) disable iff (rst)
    fire |=> $stable(handler));
endmodule

// File: rtl/rww_unit.sv
module rww_unit #(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 6,
  parameter int SRC_W    = 2,
  parameter int CORE_ID  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_arg,
  input  logic [ADDR_W-1:0] core_pc,
  input  logic              snp_valid,
  input  logic              snp_write,
  input  logic [SRC_W-1:0]  snp_src,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              mark_ack,
  output logic              mark_was_set,
  output logic              watch_active,
  output logic              alert_en,
  output logic              alert,
  output logic [ADDR_W-1:0] alert_vec,
  output logic [ADDR_W-1:0] saved_pc
);
  import rww_pkg::*;

  localparam int LINE_W = ADDR_W - OFFSET_W;
  localparam logic [SRC_W-1:0] OWN_SRC = SRC_W'(CORE_ID);

  logic              set_handler_req, mark_req, release_req, enable_req;
  logic              remote_hit, fire;
  logic [LINE_W-1:0] watch_line;

  assign set_handler_req = cmd_valid && (cmd_op == OP_SET_HANDLER);
  assign mark_req        = cmd_valid && (cmd_op == OP_MARK);
  assign release_req     = cmd_valid && (cmd_op == OP_RELEASE);
  assign enable_req      = cmd_valid && (cmd_op == OP_ENABLE);

  rww_line_match #(
    .ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .SRC_W(SRC_W), .CORE_ID(CORE_ID)
  ) u_match (
    .snp_valid  (snp_valid),
    .snp_write  (snp_write),
    .snp_src    (snp_src),
    .snp_addr   (snp_addr),
    .watch_line (watch_line),
    .watch_valid(watch_active),
    .remote_hit (remote_hit)
  );

  assign fire = remote_hit && alert_en;

  rww_watch_reg #(.LINE_W(LINE_W)) u_watch (
    .clk         (clk),
    .rst         (rst),
    .mark_req    (mark_req),
    .release_req (release_req),
    .fire        (fire),
    .mark_line   (cmd_arg[ADDR_W-1:OFFSET_W]),
    .watch_line  (watch_line),
    .watch_valid (watch_active),
    .mark_ack    (mark_ack),
    .mark_was_set(mark_was_set)
  );

  rww_arch_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk            (clk),
    .rst            (rst),
    .set_handler_req(set_handler_req),
    .release_req    (release_req),
    .enable_req     (enable_req),
    .handler_in     (cmd_arg),
    .fire           (fire),
    .core_pc        (core_pc),
    .handler        (alert_vec),
    .saved_pc       (saved_pc),
    .enable         (alert_en),
    .alert          (alert)
  );

  // R4: an alert follows a cycle with a live watch and enabled alerts
  p_alert_needs_watch_r4: assert property (@(posedge clk) disable iff (rst)
    alert |-> $past(watch_active && alert_en));
  // R7: own-source snoops never lead to an alert
  p_own_src_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && snp_src == OWN_SRC) |=> !alert);
  // R7: read snoops never lead to an alert
  p_read_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && !snp_write) |=> !alert);
  // R8: a masked hit keeps the watch
  p_masked_keeps_r8: assert property (@(posedge clk) disable iff (rst)
    (!alert_en && watch_active && !cmd_valid) |=> watch_active);
endmodule

// File: tb/rww_unit_tb.sv
module rww_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [31:0] cmd_arg, core_pc, snp_addr;
  logic        snp_valid, snp_write;
  logic [1:0]  snp_src;
  logic        mark_ack, mark_was_set, watch_active, alert_en, alert;
  logic [31:0] alert_vec, saved_pc;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  rww_unit u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .core_pc(core_pc), .snp_valid(snp_valid),
    .snp_write(snp_write), .snp_src(snp_src), .snp_addr(snp_addr),
    .mark_ack(mark_ack), .mark_was_set(mark_was_set),
    .watch_active(watch_active), .alert_en(alert_en), .alert(alert),
    .alert_vec(alert_vec), .saved_pc(saved_pc)
  );

  typedef struct packed {
    logic        c;    logic [1:0] op; logic [31:0] arg;
    logic        s;    logic w;        logic [1:0]  src;
    logic [31:0] addr; logic [31:0] pc;
    logic        ea;   logic ew;       logic ee;    logic ek; logic es;
    logic [31:0] ev;   logic [31:0] ep; logic [3:0] rq;
  } row_t;

  localparam int N = 14;
  localparam row_t TBL [0:N-1] = '{
    // R2 set handler
    '{1'b1,2'd0,32'h1000, 1'b0,1'b0,2'd0,32'h0,32'h0,   1'b0,1'b0,1'b0,1'b0,1'b0, 32'h1000,32'h0,   4'd2},
    // R3 first mark
    '{1'b1,2'd1,32'h2044, 1'b0,1'b0,2'd0,32'h0,32'h0,   1'b0,1'b1,1'b0,1'b1,1'b0, 32'h1000,32'h0,   4'd3},
    // R3 re-mark same line, other offset
    '{1'b1,2'd1,32'h2078, 1'b0,1'b0,2'd0,32'h0,32'h0,   1'b0,1'b1,1'b0,1'b1,1'b1, 32'h1000,32'h0,   4'd3},
    // R8 hit while disabled
    '{1'b0,2'd0,32'h0,    1'b1,1'b1,2'd1,32'h2050,32'h111, 1'b0,1'b1,1'b0,1'b0,1'b0, 32'h1000,32'h0, 4'd8},
    // R10 enable
    '{1'b1,2'd3,32'h0,    1'b0,1'b0,2'd0,32'h0,32'h0,   1'b0,1'b1,1'b1,1'b0,1'b0, 32'h1000,32'h0,   4'd10},
    // R7 own-source write
    '{1'b0,2'd0,32'h0,    1'b1,1'b1,2'd0,32'h2040,32'h222, 1'b0,1'b1,1'b1,1'b0,1'b0, 32'h1000,32'h0, 4'd7},
    // R7 remote read
    '{1'b0,2'd0,32'h0,    1'b1,1'b0,2'd1,32'h2040,32'h333, 1'b0,1'b1,1'b1,1'b0,1'b0, 32'h1000,32'h0, 4'd7},
    // R5 neighbouring line
    '{1'b0,2'd0,32'h0,    1'b1,1'b1,2'd1,32'h2080,32'h444, 1'b0,1'b1,1'b1,1'b0,1'b0, 32'h1000,32'h0, 4'd5},
    // R4 hit at last byte of the line
    '{1'b0,2'd0,32'h0,    1'b1,1'b1,2'd1,32'h207F,32'h5550, 1'b1,1'b0,1'b0,1'b0,1'b0, 32'h1000,32'h5550, 4'd4},
    // R10 enable again
    '{1'b1,2'd3,32'h0,    1'b0,1'b0,2'd0,32'h0,32'h0,   1'b0,1'b0,1'b1,1'b0,1'b0, 32'h1000,32'h5550, 4'd10},
    // R6 watch gone after alert
    '{1'b0,2'd0,32'h0,    1'b1,1'b1,2'd1,32'h2040,32'h777, 1'b0,1'b0,1'b1,1'b0,1'b0, 32'h1000,32'h5550, 4'd6},
    // R3 new mark
    '{1'b1,2'd1,32'h3000, 1'b0,1'b0,2'd0,32'h0,32'h0,   1'b0,1'b1,1'b1,1'b1,1'b0, 32'h1000,32'h5550, 4'd3},
    // R9 release clears watch and handler
    '{1'b1,2'd2,32'h0,    1'b0,1'b0,2'd0,32'h0,32'h0,   1'b0,1'b0,1'b1,1'b0,1'b0, 32'h0,32'h5550,    4'd9},
    // R3 mark after release is fresh
    '{1'b1,2'd1,32'h3004, 1'b0,1'b0,2'd0,32'h0,32'h0,   1'b0,1'b1,1'b1,1'b1,1'b0, 32'h0,32'h5550,    4'd3}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_in();
    cmd_valid = 1'b0; cmd_op = 2'd0; cmd_arg = '0;
    snp_valid = 1'b0; snp_write = 1'b0; snp_src = 2'd0; snp_addr = '0;
  endtask

  task automatic step(input bit c, input logic [1:0] op, input logic [31:0] arg,
                      input bit s, input bit w, input logic [1:0] src,
                      input logic [31:0] addr, input logic [31:0] pc);
    cmd_valid = c; cmd_op = op; cmd_arg = arg;
    snp_valid = s; snp_write = w; snp_src = src; snp_addr = addr; core_pc = pc;
    @(posedge clk); @(negedge clk);
    idle_in();
  endtask

  task automatic check_reset(input string tag);
    chk(!watch_active && !alert_en && !alert && !mark_ack && !mark_was_set,
        tag, {27'd0, watch_active, alert_en, alert, mark_ack, mark_was_set}, 32'd0);
    chk(alert_vec == 0 && saved_pc == 0, tag, alert_vec | saved_pc, 32'd0);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<=100000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int hits;
    idle_in();
    core_pc = '0;
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    check_reset("R1 after reset");

    for (int i = 0; i < N; i++) begin
      step(TBL[i].c, TBL[i].op, TBL[i].arg, TBL[i].s, TBL[i].w, TBL[i].src,
           TBL[i].addr, TBL[i].pc);
      total++;
      if ({alert, watch_active, alert_en, mark_ack, mark_was_set} !==
            {TBL[i].ea, TBL[i].ew, TBL[i].ee, TBL[i].ek, TBL[i].es}
          || alert_vec !== TBL[i].ev || saved_pc !== TBL[i].ep) begin
        bad++;
        $display("FAIL R%0d row %0d actual=%b/%h/%h expected=%b/%h/%h",
                 TBL[i].rq, i,
                 {alert, watch_active, alert_en, mark_ack, mark_was_set},
                 alert_vec, saved_pc,
                 {TBL[i].ea, TBL[i].ew, TBL[i].ee, TBL[i].ek, TBL[i].es},
                 TBL[i].ev, TBL[i].ep);
      end
    end

    // R11: command in the alert cycle is dropped
    step(1'b1, 2'd0, 32'h7000, 1'b0, 1'b0, 2'd0, 32'h0, 32'h0);
    chk(alert_vec == 32'h7000, "R2 handler reload", alert_vec, 32'h7000);
    step(1'b1, 2'd0, 32'h9000, 1'b1, 1'b1, 2'd1, 32'h3010, 32'h6660);
    chk(alert == 1'b1, "R11 alert wins", {31'd0, alert}, 32'd1);
    chk(alert_vec == 32'h7000, "R11 handler unchanged", alert_vec, 32'h7000);
    chk(saved_pc == 32'h6660, "R4 pc captured", saved_pc, 32'h6660);
    chk(!watch_active && !alert_en, "R6 cleared on alert",
        {30'd0, watch_active, alert_en}, 32'd0);
    step(1'b0, 2'd0, 32'h0, 1'b0, 1'b0, 2'd0, 32'h0, 32'h0);
    chk(alert == 1'b0, "R4 single-cycle alert", {31'd0, alert}, 32'd0);

    // R11: a mark in the alert cycle produces no ack
    step(1'b1, 2'd1, 32'h4000, 1'b0, 1'b0, 2'd0, 32'h0, 32'h0);
    step(1'b1, 2'd3, 32'h0, 1'b0, 1'b0, 2'd0, 32'h0, 32'h0);
    step(1'b1, 2'd1, 32'h8000, 1'b1, 1'b1, 2'd1, 32'h4008, 32'h1234);
    chk(alert && !mark_ack && !watch_active, "R11 mark dropped",
        {29'd0, alert, mark_ack, watch_active}, 32'd4);

    // R12: watch survives many unrelated snoops
    step(1'b1, 2'd1, 32'h4000, 1'b0, 1'b0, 2'd0, 32'h0, 32'h0);
    step(1'b1, 2'd3, 32'h0, 1'b0, 1'b0, 2'd0, 32'h0, 32'h0);
    hits = 0;
    for (int k = 0; k < 40; k++) begin
      if (k % 2 == 0) step(1'b0, 2'd0, 32'h0, 1'b1, 1'b0, 2'd2, 32'h4000, 32'h0);
      else            step(1'b0, 2'd0, 32'h0, 1'b1, 1'b1, 2'd3, 32'h5000 + k, 32'h0);
      if (alert) hits++;
    end
    chk(hits == 0, "R12 no spurious alert", hits, 32'd0);
    chk(watch_active && alert_en, "R12 watch persists",
        {30'd0, watch_active, alert_en}, 32'd3);
    step(1'b0, 2'd0, 32'h0, 1'b1, 1'b1, 2'd1, 32'h4020, 32'hABCD);
    chk(alert && saved_pc == 32'hABCD, "R12 late hit", saved_pc, 32'hABCD);

    // R1: mid-run reset
    step(1'b1, 2'd0, 32'h1111, 1'b0, 1'b0, 2'd0, 32'h0, 32'h0);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    check_reset("R1 mid-run reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule